// File: doc/BRIEF.md
# Dual-Channel Nibble-Framed Serial Receiver

This block takes one asynchronous serial input and turns it into characters. Each character has one start bit, eight data bits sent least significant bit first, one odd parity bit and two stop bits. The line is sampled on a tick that runs at sixteen times the baud rate. Every finished character goes into a one-entry holding register, together with flags for framing, parity and overrun errors. A decoder state machine reads that register.

The decoder serves two logical channels. A character with its top bit clear is a 7-bit channel item and is passed on unchanged. A character with its top bit set carries one nibble of an 8-bit channel byte. Bit 6 tells whether it is the low half (0) or the high half (1). The decoder pairs a low half with the high half that follows it and emits the rebuilt byte. Any line error drops the character and discards a half-received pair. It also raises one error strobe, which applies to both channels and carries zero data.

The `dec_en` input lets the decoder consume the holding register. While `dec_en` is low, a finished character waits in the register. If another character finishes during that time, the result is an overrun.

Top module: `nibrx_top`

States:
- Receiver: RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP1, RX_STOP2, RX_WAIT_HIGH.
  - RX_IDLE goes to RX_START when a low sample is seen.
  - RX_START goes to RX_DATA if the mid-bit sample is still low, otherwise back to RX_IDLE.
  - RX_DATA goes to RX_PARITY after eight bits.
  - RX_PARITY goes to RX_STOP1, and RX_STOP1 goes to RX_STOP2.
  - RX_STOP2 goes to RX_IDLE if its sample is high, or to RX_WAIT_HIGH if its sample is low.
  - RX_WAIT_HIGH goes to RX_IDLE once the line is high.
- Decoder: PEND_NONE and PEND_LOW.
  - PEND_NONE goes to PEND_LOW on a low-half character.
  - PEND_LOW goes back to PEND_NONE on any consumed character.

## Requirements
- R1: A character is start(0), eight data bits LSB first, parity, stop, stop; each bit is sampled once at its mid-bit point of a 16-tick bit time; parity is odd, so the data bits plus the parity bit hold an odd number of ones.
- R2: A low level that has gone back high by the mid-point of the start bit is ignored and produces no character.
- R3: A clean character with bit 7 = 0 produces a one-cycle `ch7_valid` with `ch7_data` equal to the character, and drops any pending low nibble.
- R4: A clean character with bits 7:6 = 10 and no pending nibble stores bits 3:0 as the low nibble and produces no output.
- R5: A clean character with bits 7:6 = 11 while a low nibble is pending produces a one-cycle `ch8_valid` with `ch8_data` = {character bits 3:0, stored low nibble}, and clears the pending state.
- R6: A clean 10-tagged character while a low nibble is pending clears the pending state and is discarded; it does not start a new pair.
- R7: A clean 11-tagged character with nothing pending is ignored.
- R8: A parity error produces a one-cycle `err_valid` with both data outputs zero, and clears the pending state.
- R9: If either stop bit samples low, the result is the same as in R8. After a low second stop bit, the receiver waits for the line to go high before it looks for a new start bit.
- R10: If a character finishes while the previous one is still held unconsumed, the held entry becomes an overrun error and the new character is lost. When the entry is consumed, it gives the same result as in R8.
- R11: At most one of the three strobes is high in any cycle, and each data output is zero whenever its strobe is low.
- R12: While `dec_en` is low, no strobe is raised and the held character is kept. It is decoded after `dec_en` returns high.
- R13: During and straight after reset, all strobes and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| dec_en | input | 1 | Lets the decoder consume the held character |
| ch7_valid | output | 1 | 7-bit channel strobe |
| ch7_data | output | 8 | 7-bit channel character (bit 7 zero) |
| ch8_valid | output | 1 | 8-bit channel strobe |
| ch8_data | output | 8 | Rebuilt 8-bit channel byte |
| err_valid | output | 1 | Line error strobe, shared by both channels |

## Verification
The two functions that can coincide in one decode step are error reporting and pair completion. A high-half character that would complete a pending pair can itself carry a line error. The bench provokes this in two ways: it sends a low half, then a high half with a flipped parity bit, and it also sends a pair whose high half has a low first stop bit. The expected result is an error strobe with zero data and no 8-bit byte. A clean high half sent next must then be ignored, which shows that the same step also dropped the pending nibble.

// File: rtl/nibrx_pkg.sv
package nibrx_pkg;
    localparam int CHAR_W = 8;
    localparam int NIB_W  = CHAR_W / 2;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              ferr;
        logic              perr;
        logic              oerr;
    } rx_char_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2,
        RX_WAIT_HIGH
    } rx_state_t;

    typedef enum logic {
        PEND_NONE,
        PEND_LOW
    } pair_state_t;
endpackage

// File: rtl/nibrx_tick.sv
module nibrx_tick #(
    parameter int CLKS_PER_TICK = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/nibrx_deser.sv
module nibrx_deser
    import nibrx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rxd,
    output logic     done,
    output rx_char_t char_o
);
    localparam int PW = $clog2(OVS);
    localparam int BW = $clog2(CHAR_W);
    localparam logic [PW-1:0] HALF = PW'(OVS / 2 - 1);
    localparam logic [PW-1:0] FULL = PW'(OVS - 1);
    localparam logic [BW-1:0] LASTBIT = BW'(CHAR_W - 1);

    logic            sync1, rx;
    rx_state_t       state, state_n;
    logic [PW-1:0]   ph;
    logic [BW-1:0]   bitn;
    logic [CHAR_W-1:0] sh;
    logic            par_q, stop1_q;
    logic            mid;

    assign mid = tick && (ph == FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            rx    <= 1'b1;
        end else begin
            sync1 <= rxd;
            rx    <= sync1;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:      if (tick && !rx) state_n = RX_START;
            RX_START:     if (tick && ph == HALF) state_n = rx ? RX_IDLE : RX_DATA;
            RX_DATA:      if (mid && bitn == LASTBIT) state_n = RX_PARITY;
            RX_PARITY:    if (mid) state_n = RX_STOP1;
            RX_STOP1:     if (mid) state_n = RX_STOP2;
            RX_STOP2:     if (mid) state_n = rx ? RX_IDLE : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (rx) state_n = RX_IDLE;
            default:      state_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= '0;
            bitn    <= '0;
            sh      <= '0;
            par_q   <= 1'b0;
            stop1_q <= 1'b1;
            done    <= 1'b0;
            char_o  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE, RX_WAIT_HIGH: begin
                        ph   <= '0;
                        bitn <= '0;
                    end
                    RX_START: ph <= (ph == HALF) ? '0 : ph + 1'b1;
                    RX_DATA: begin
                        ph <= ph + 1'b1;
                        if (ph == FULL) begin
                            sh   <= {rx, sh[CHAR_W-1:1]};
                            bitn <= bitn + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        ph <= ph + 1'b1;
                        if (ph == FULL) par_q <= rx;
                    end
                    RX_STOP1: begin
                        ph <= ph + 1'b1;
                        if (ph == FULL) stop1_q <= rx;
                    end
                    RX_STOP2: begin
                        ph <= ph + 1'b1;
                        if (ph == FULL) begin
                            done        <= 1'b1;
                            char_o.data <= sh;
                            char_o.perr <= ~(^{sh, par_q});
                            char_o.ferr <= ~(stop1_q & rx);
                            char_o.oerr <= 1'b0;
                        end
                    end
                    default: ph <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/nibrx_hold.sv
module nibrx_hold
    import nibrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     done,
    input  rx_char_t char_i,
    input  logic     take,
    output logic     full,
    output rx_char_t char_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            char_q <= '0;
        end else begin
            if (done && full && !take) begin
                char_q.oerr <= 1'b1;
            end else if (done) begin
                char_q <= char_i;
            end
            full <= (full && !take) || done;
        end
    end
endmodule

// File: rtl/nibrx_decode.sv
module nibrx_decode
    import nibrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  rx_char_t          char_i,
    output logic              ch7_valid,
    output logic [CHAR_W-1:0] ch7_data,
    output logic              ch8_valid,
    output logic [CHAR_W-1:0] ch8_data,
    output logic              err_valid
);
    pair_state_t      st, st_n;
    logic [NIB_W-1:0] low_q;
    logic             bad, e7, e8, eerr, store;

    assign bad = char_i.ferr | char_i.perr | char_i.oerr;

    always_comb begin
        st_n  = st;
        e7    = 1'b0;
        e8    = 1'b0;
        eerr  = 1'b0;
        store = 1'b0;
        if (take) begin
            if (bad) begin
                eerr = 1'b1;
                st_n = PEND_NONE;
            end else if (!char_i.data[CHAR_W-1]) begin
                e7   = 1'b1;
                st_n = PEND_NONE;
            end else begin
                unique case (st)
                    PEND_NONE: begin
                        if (!char_i.data[CHAR_W-2]) begin
                            store = 1'b1;
                            st_n  = PEND_LOW;
                        end
                    end
                    PEND_LOW: begin
                        e8   = char_i.data[CHAR_W-2];
                        st_n = PEND_NONE;
                    end
                    default: st_n = PEND_NONE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= PEND_NONE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q     <= '0;
            ch7_valid <= 1'b0;
            ch7_data  <= '0;
            ch8_valid <= 1'b0;
            ch8_data  <= '0;
            err_valid <= 1'b0;
        end else begin
            if (store) low_q <= char_i.data[NIB_W-1:0];
            ch7_valid <= e7;
            ch7_data  <= e7 ? char_i.data : '0;
            ch8_valid <= e8;
            ch8_data  <= e8 ? {char_i.data[NIB_W-1:0], low_q} : '0;
            err_valid <= eerr;
        end
    end
endmodule

// File: rtl/nibrx_top.sv
module nibrx_top
    import nibrx_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4,
    parameter int OVS           = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       dec_en,
    output logic       ch7_valid,
    output logic [7:0] ch7_data,
    output logic       ch8_valid,
    output logic [7:0] ch8_data,
    output logic       err_valid
);
    logic     tick, char_done, hold_full, take;
    rx_char_t new_char, hold_q;

    assign take = hold_full && dec_en;

    nibrx_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    nibrx_deser #(.OVS(OVS)) u_deser (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .done(char_done), .char_o(new_char)
    );

    nibrx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .done(char_done), .char_i(new_char),
        .take(take), .full(hold_full), .char_q(hold_q)
    );

    nibrx_decode u_dec (
        .clk(clk), .rst_n(rst_n), .take(take), .char_i(hold_q),
        .ch7_valid(ch7_valid), .ch7_data(ch7_data),
        .ch8_valid(ch8_valid), .ch8_data(ch8_data),
        .err_valid(err_valid)
    );
endmodule

// File: rtl/nibrx_sva.sv
module nibrx_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       dec_en,
    input logic       ch7_valid,
    input logic [7:0] ch7_data,
    input logic       ch8_valid,
    input logic [7:0] ch8_data,
    input logic       err_valid,
    input logic       char_done,
    input logic       hold_full,
    input logic       hold_oerr
);
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch7_valid, ch8_valid, err_valid}));

    a_r11_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch7_valid |-> ch7_data == 8'h00) and (!ch8_valid |-> ch8_data == 8'h00));

    a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (ch7_data == 8'h00 && ch8_data == 8'h00));

    a_r3_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ch7_valid |-> !ch7_data[7]);

    a_r12_stalled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> !(ch7_valid || ch8_valid || err_valid));

    a_r10_overrun_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && hold_full && !dec_en) |=> (hold_full && hold_oerr));
endmodule

bind nibrx_top nibrx_sva u_sva (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en),
    .ch7_valid(ch7_valid), .ch7_data(ch7_data),
    .ch8_valid(ch8_valid), .ch8_data(ch8_data),
    .err_valid(err_valid), .char_done(char_done),
    .hold_full(hold_full), .hold_oerr(hold_q.oerr)
);

// File: tb/nibrx_top_bench.sv
`timescale 1ns/1ps
module nibrx_top_bench;
    localparam int CPT      = 4;
    localparam int BIT_CLKS = CPT * 16;
    localparam int K7 = 0, K8 = 1, KERR = 2;

    typedef struct {
        int         kind;
        logic [7:0] data;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       dec_en = 1'b1;
    logic       ch7_valid, ch8_valid, err_valid;
    logic [7:0] ch7_data, ch8_data;

    exp_t       q[$];
    int         n_chk = 0, n_fail = 0;
    bit         pend = 0;
    logic [3:0] low_m = '0;
    bit         finished = 0;

    always #5 clk = ~clk;

    nibrx_top #(.CLKS_PER_TICK(CPT), .OVS(16)) u_nibrx_top (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .dec_en(dec_en),
        .ch7_valid(ch7_valid), .ch7_data(ch7_data),
        .ch8_valid(ch8_valid), .ch8_data(ch8_data),
        .err_valid(err_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push(input int kind, input logic [7:0] d, input string req);
        exp_t e;
        e.kind = kind; e.data = d; e.req = req;
        q.push_back(e);
    endtask

    // reference model of the two-channel decode
    task automatic model(input logic [7:0] b, input bit err, input string req);
        if (err) begin
            push(KERR, 8'h00, req);
            pend = 0;
        end else if (!b[7]) begin
            push(K7, b, req);
            pend = 0;
        end else if (!b[6]) begin
            if (!pend) begin pend = 1; low_m = b[3:0]; end
            else pend = 0;
        end else begin
            if (pend) push(K8, {b[3:0], low_m}, req);
            pend = 0;
        end
    endtask

    task automatic line_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] b, input bit bad_par, input bit bad_s1, input bit bad_s2);
        logic p;
        p = ~(^b) ^ bad_par;
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(b[i]);
        line_bit(p);
        line_bit(~bad_s1);
        line_bit(~bad_s2);
        line_bit(1'b1);
    endtask

    task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_s1,
                        input bit bad_s2, input string req);
        model(b, bad_par | bad_s1 | bad_s2, req);
        frame(b, bad_par, bad_s1, bad_s2);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (ch7_valid || ch8_valid || err_valid)) begin
            if (q.size() == 0) begin
                check(0, "R2 unexpected strobe", {ch7_valid, ch8_valid, err_valid}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                case (e.kind)
                    K7: check(ch7_valid && !ch8_valid && !err_valid && ch7_data == e.data,
                              e.req, {ch7_valid, ch7_data}, {1'b1, e.data});
                    K8: check(ch8_valid && !ch7_valid && !err_valid && ch8_data == e.data,
                              e.req, {ch8_valid, ch8_data}, {1'b1, e.data});
                    default: check(err_valid && !ch7_valid && !ch8_valid &&
                                   ch7_data == 0 && ch8_data == 0,
                                   e.req, {err_valid, ch7_data, ch8_data}, 17'h10000);
                endcase
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "R1 watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        check(!ch7_valid && !ch8_valid && !err_valid && ch7_data == 0 && ch8_data == 0,
              "R13 outputs in reset", {ch7_valid, ch8_valid, err_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ch7_valid && !ch8_valid && !err_valid, "R13 after reset",
              {ch7_valid, ch8_valid, err_valid}, 0);
        repeat (BIT_CLKS) @(negedge clk);

        // R2: short glitch, then a real character
        rxd = 1'b0;
        repeat (3 * CPT) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        check(q.size() == 0, "R2 glitch ignored", q.size(), 0);

        // R1 / R3: 7-bit channel patterns
        send(8'h5A, 0, 0, 0, "R1 R3 7-bit 5A");
        send(8'h00, 0, 0, 0, "R3 7-bit 00");
        send(8'h7F, 0, 0, 0, "R1 7-bit 7F");

        // R4 / R5: pairs
        send(8'h8C, 0, 0, 0, "R4 low nibble");
        send(8'hC3, 0, 0, 0, "R5 pair 3C");
        send(8'h8F, 0, 0, 0, "R4 low nibble");
        send(8'hCA, 0, 0, 0, "R5 pair AF");

        // R7: lone high nibble ignored
        send(8'hC5, 0, 0, 0, "R7 lone high");
        send(8'h41, 0, 0, 0, "R7 followed by 41");

        // R6: second low discards pair and does not restart it
        send(8'h81, 0, 0, 0, "R6 first low");
        send(8'h82, 0, 0, 0, "R6 second low");
        send(8'hC7, 0, 0, 0, "R6 high after discard");
        send(8'h8E, 0, 0, 0, "R6 fresh low");
        send(8'hC1, 0, 0, 0, "R6 fresh pair 1E");

        // R3: 7-bit char clears pending
        send(8'h84, 0, 0, 0, "R3 low before 7-bit");
        send(8'h12, 0, 0, 0, "R3 7-bit 12");
        send(8'hC9, 0, 0, 0, "R3 high ignored");

        // R8: parity error on the completing half
        send(8'h85, 0, 0, 0, "R8 low");
        send(8'hC6, 1, 0, 0, "R8 parity error");
        send(8'hC6, 0, 0, 0, "R8 high ignored after error");

        // R9: framing errors
        send(8'h86, 0, 0, 0, "R9 low");
        send(8'hC2, 0, 1, 0, "R9 stop1 low");
        send(8'hC2, 0, 0, 0, "R9 high ignored after error");
        send(8'h33, 0, 0, 1, "R9 stop2 low");
        send(8'h6B, 0, 0, 0, "R9 recovery 6B");

        // R12: stall keeps the character
        dec_en = 1'b0;
        send(8'h35, 0, 0, 0, "R12 held char");
        repeat (100) @(negedge clk);
        check(q.size() == 1, "R12 nothing while stalled", q.size(), 1);
        dec_en = 1'b1;
        repeat (5) @(negedge clk);
        check(q.size() == 0, "R12 delivered after release", q.size(), 0);

        // R10: overrun
        dec_en = 1'b0;
        frame(8'h11, 0, 0, 0);
        frame(8'h22, 0, 0, 0);
        model(8'h00, 1, "R10 overrun error");
        repeat (20) @(negedge clk);
        dec_en = 1'b1;
        repeat (5) @(negedge clk);
        check(q.size() == 0, "R10 overrun reported", q.size(), 0);
        send(8'h66, 0, 0, 0, "R10 recovery 66");

        repeat (20) @(negedge clk);
        check(q.size() == 0, "R11 all expected items seen", q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule